// File: doc/BRIEF.md
# Multidrop Bus Slave Frame Engine

This block is the frame-level logic of a slave station on a half-duplex serial control bus that has one master and many slaves. An external UART receiver supplies received bytes one at a time. The engine assembles them into frames and checks an 8-bit CRC. It compares the 16-bit destination address with the node's own strapped address. Accepted commands write to or read from two separate register spaces of up to 256 bytes each: measurement channels and configuration parameters.

Replies go out through an external UART transmitter over a valid/ready byte handshake. The engine drives the line-driver enable early enough to give one bit time of lead before the first reply byte. It keeps the enable on until the transmitter reports that the stop bit of the last byte has left.

A request frame has this byte order: command, destination address high, destination address low, register index, then 0 to 7 data bytes, then the CRC. The command byte has these fields:
- Bits 2:0 give the data byte count.
- Bits 6:5 select the operation.
- Bit 7 requests an acknowledge.

Top module: `slow_node_if`

## Requirements
- R1: A frame whose address field (byte 1 high, byte 2 low) differs from `node_addr_i` causes no reply and no register change, and it is consumed whole, so that a frame sent right after it is decoded correctly.
- R2: Every frame is command, address high, address low, index, N data bytes, CRC, where N = command[2:0]. Command[6:5] selects the operation: 00 write channel, 01 write parameter, 10 read channel, 11 read parameter.
- R3: The CRC is CRC-8 with polynomial 0x31 (x^8+x^5+x^4+1), initial value 0, MSB first, no final XOR, computed over all earlier bytes of the frame. A frame with a wrong CRC causes no reply and no register change.
- R4: A write stores its N data bytes at index, index+1, and so on, wrapping modulo 256. Indices at or above the space size are dropped. Nothing is written until the CRC has been checked.
- R5: A write with command[7]=1 returns the two-byte acknowledge 0xA0, CRC. A write with command[7]=0 returns nothing.
- R6: A read always returns 0xA1, the byte stored at the index, CRC. The channel space and the parameter space are separate, so the same index holds independent values in each.
- R7: If a frame is partly received and no byte arrives for more than `gap_cycles_i` clock cycles, the partial frame is dropped and the next byte is taken as a command.
- R8: `tx_en_o` rises at least `bit_cycles_i` cycles before the first `tx_valid_o`. It stays high until `tx_ready_i` returns high after the last byte. The transmitter must lower `tx_ready_i` the cycle after it accepts a byte and hold it low until that byte's stop bit has been sent.
- R9: After reset, `tx_en_o` and `tx_valid_o` are low and all registers read 0.
- R10: `tx_valid_o` and `tx_data_o` stay stable until the byte is accepted (`tx_valid_o` and `tx_ready_i` both high at a clock edge).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| node_addr_i | input | 16 | Address of this node |
| gap_cycles_i | input | 16 | Inter-byte silence limit, in cycles |
| bit_cycles_i | input | 16 | One bit time, in cycles, used as enable lead |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| tx_ready_i | input | 1 | Transmitter idle and ready for a byte |
| tx_en_o | output | 1 | Line driver enable |
| tx_valid_o | output | 1 | Reply byte valid |
| tx_data_o | output | 8 | Reply byte |

## Verification
The hardest condition to reach is a parser left out of step with frame boundaries. Two cases lead there. In one, a frame is abandoned halfway. In the other, a frame carrying data bytes is addressed to a different node and must still be consumed to its last byte. The stimulus creates both cases. It sends a truncated frame, stays silent past the gap limit, and then sends a valid write. It also sends a multi-byte frame for a foreign address followed immediately by a read. A misaligned parser would return a wrong reply or no reply at all. A sweep of writes and read-backs across both spaces, at indices spread over the full byte range, then confirms that the two spaces are separate and that multi-byte writes wrap correctly at index 255.

// File: rtl/slow_node_pkg.sv
package slow_node_pkg;
  typedef enum logic [1:0] {
    OP_WR_CHAN = 2'd0,
    OP_WR_PARM = 2'd1,
    OP_RD_CHAN = 2'd2,
    OP_RD_PARM = 2'd3
  } op_e;

  localparam logic [7:0] RPL_HDR = 8'hA0;
  localparam logic [7:0] CRC_POLY = 8'h31;

  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    return r;
  endfunction
endpackage

// File: rtl/slow_node_rx.sv
module slow_node_rx
  import slow_node_pkg::*;
#(
  parameter int LEN_W = 3,
  parameter int GAP_W = 16,
  localparam int MAX_LEN = (1 << LEN_W) - 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [15:0]                  node_addr_i,
  input  logic [GAP_W-1:0]             gap_cycles_i,
  input  logic                         rx_valid_i,
  input  logic [7:0]                   rx_data_i,
  input  logic                         hold_i,
  output logic                         frame_ok_o,
  output logic [7:0]                   cmd_o,
  output logic [7:0]                   index_o,
  output logic [MAX_LEN-1:0][7:0]      data_o
);
  localparam int POS_W = $clog2(MAX_LEN + 6);

  logic [POS_W-1:0] pos_q, last_pos;
  logic [GAP_W-1:0] gap_q;
  logic [7:0]       crc_q, cmd_q, idx_q;
  logic [15:0]      addr_q;
  logic [MAX_LEN-1:0][7:0] dat_q;
  logic             ok_q, take;

  assign take     = rx_valid_i && !hold_i;
  assign last_pos = POS_W'(4) + POS_W'(cmd_q[LEN_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      gap_q  <= '0;
      crc_q  <= '0;
      cmd_q  <= '0;
      idx_q  <= '0;
      addr_q <= '0;
      dat_q  <= '0;
      ok_q   <= 1'b0;
    end else begin
      ok_q <= 1'b0;
      if (take) begin
        gap_q <= '0;
        crc_q <= crc8_step((pos_q == '0) ? 8'h00 : crc_q, rx_data_i);
        if (pos_q == POS_W'(0)) cmd_q <= rx_data_i;
        if (pos_q == POS_W'(1)) addr_q[15:8] <= rx_data_i;
        if (pos_q == POS_W'(2)) addr_q[7:0] <= rx_data_i;
        if (pos_q == POS_W'(3)) idx_q <= rx_data_i;
        for (int k = 0; k < MAX_LEN; k++)
          if (pos_q == POS_W'(4 + k)) dat_q[k] <= rx_data_i;
        if (pos_q >= POS_W'(4) && pos_q == last_pos) begin
          pos_q <= '0;
          ok_q  <= (crc8_step(crc_q, rx_data_i) == 8'h00) && (addr_q == node_addr_i);
        end else begin
          pos_q <= pos_q + POS_W'(1);
        end
      end else if (pos_q != '0) begin
        // silence mid-frame: drop partial frame
        if (gap_q >= gap_cycles_i) pos_q <= '0;
        else gap_q <= gap_q + GAP_W'(1);
      end
    end
  end

  assign frame_ok_o = ok_q;
  assign cmd_o      = cmd_q;
  assign index_o    = idx_q;
  assign data_o     = dat_q;

  a_r3_ok_follows_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_q |-> $past(take));
  a_r3_ok_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_q |=> !ok_q);
endmodule

// File: rtl/slow_node_regs.sv
module slow_node_regs #(
  parameter int N_CHAN  = 256,
  parameter int N_PARAM = 256,
  parameter int LEN_W   = 3,
  localparam int MAX_LEN = (1 << LEN_W) - 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic                    wr_parm_i,
  input  logic [7:0]              wr_idx_i,
  input  logic [LEN_W-1:0]        wr_len_i,
  input  logic [MAX_LEN-1:0][7:0] wr_data_i,
  input  logic                    rd_parm_i,
  input  logic [7:0]              rd_idx_i,
  output logic [7:0]              rd_data_o
);
  logic [7:0] chan_q [N_CHAN];
  logic [7:0] parm_q [N_PARAM];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_CHAN; i++) chan_q[i] <= '0;
      for (int i = 0; i < N_PARAM; i++) parm_q[i] <= '0;
    end else if (wr_en_i) begin
      for (int k = 0; k < MAX_LEN; k++) begin
        if (k < int'(wr_len_i)) begin
          if (!wr_parm_i && int'(8'(wr_idx_i + 8'(k))) < N_CHAN)
            chan_q[8'(wr_idx_i + 8'(k))] <= wr_data_i[k];
          if (wr_parm_i && int'(8'(wr_idx_i + 8'(k))) < N_PARAM)
            parm_q[8'(wr_idx_i + 8'(k))] <= wr_data_i[k];
        end
      end
    end
  end

  always_comb begin
    rd_data_o = 8'h00;
    if (rd_parm_i) begin
      if (int'(rd_idx_i) < N_PARAM) rd_data_o = parm_q[rd_idx_i];
    end else begin
      if (int'(rd_idx_i) < N_CHAN) rd_data_o = chan_q[rd_idx_i];
    end
  end
endmodule

// File: rtl/slow_node_tx.sv
module slow_node_tx
  import slow_node_pkg::*;
#(
  parameter int BIT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             has_data_i,
  input  logic [7:0]       data_i,
  input  logic [BIT_W-1:0] bit_cycles_i,
  input  logic             tx_ready_i,
  output logic             tx_en_o,
  output logic             tx_valid_o,
  output logic [7:0]       tx_data_o
);
  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_SEND, S_DRAIN} state_e;

  state_e           st_q;
  logic [BIT_W-1:0] cnt_q;
  logic [1:0]       bidx_q;
  logic [7:0]       crc_q, dat_q;
  logic             has_q, last;

  always_comb begin
    unique case (bidx_q)
      2'd0:    tx_data_o = RPL_HDR | {7'd0, has_q};
      2'd1:    tx_data_o = has_q ? dat_q : crc_q;
      default: tx_data_o = crc_q;
    endcase
  end

  assign last       = (bidx_q == {1'b0, has_q} + 2'd1);
  assign tx_valid_o = (st_q == S_SEND);
  assign tx_en_o    = (st_q != S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      bidx_q <= '0;
      crc_q  <= '0;
      dat_q  <= '0;
      has_q  <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          st_q   <= S_LEAD;
          has_q  <= has_data_i;
          dat_q  <= data_i;
          cnt_q  <= '0;
          bidx_q <= '0;
          crc_q  <= '0;
        end
        S_LEAD: begin
          if (cnt_q + BIT_W'(1) >= bit_cycles_i) st_q <= S_SEND;
          else cnt_q <= cnt_q + BIT_W'(1);
        end
        S_SEND: if (tx_ready_i) begin
          crc_q <= crc8_step(crc_q, tx_data_o);
          if (last) st_q <= S_DRAIN;
          else bidx_q <= bidx_q + 2'd1;
        end
        default: if (tx_ready_i) st_q <= S_IDLE; // last stop bit gone
      endcase
    end
  end

  a_r10_hold_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));
  a_r8_release_after_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_en_o) |-> $past(tx_ready_i));
endmodule

// File: rtl/slow_node_if.sv
module slow_node_if
  import slow_node_pkg::*;
#(
  parameter int N_CHAN  = 256,
  parameter int N_PARAM = 256,
  parameter int LEN_W   = 3,
  parameter int GAP_W   = 16,
  parameter int BIT_W   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [15:0]      node_addr_i,
  input  logic [GAP_W-1:0] gap_cycles_i,
  input  logic [BIT_W-1:0] bit_cycles_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  input  logic             tx_ready_i,
  output logic             tx_en_o,
  output logic             tx_valid_o,
  output logic [7:0]       tx_data_o
);
  localparam int MAX_LEN = (1 << LEN_W) - 1;

  logic                    frame_ok, wr_en, start;
  logic [7:0]              cmd, index, rd_data;
  logic [MAX_LEN-1:0][7:0] data;
  op_e                     op;

  assign op    = op_e'(cmd[6:5]);
  assign wr_en = frame_ok && (op == OP_WR_CHAN || op == OP_WR_PARM);
  assign start = frame_ok && (cmd[7] || op == OP_RD_CHAN || op == OP_RD_PARM);

  slow_node_rx #(.LEN_W(LEN_W), .GAP_W(GAP_W)) rx_i (
    .clk_i, .rst_ni, .node_addr_i, .gap_cycles_i, .rx_valid_i, .rx_data_i,
    .hold_i(tx_en_o), .frame_ok_o(frame_ok), .cmd_o(cmd), .index_o(index), .data_o(data)
  );

  slow_node_regs #(.N_CHAN(N_CHAN), .N_PARAM(N_PARAM), .LEN_W(LEN_W)) regs_i (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_parm_i(cmd[5]), .wr_idx_i(index),
    .wr_len_i(cmd[LEN_W-1:0]), .wr_data_i(data), .rd_parm_i(cmd[5]), .rd_idx_i(index),
    .rd_data_o(rd_data)
  );

  slow_node_tx #(.BIT_W(BIT_W)) tx_i (
    .clk_i, .rst_ni, .start_i(start), .has_data_i(cmd[6]), .data_i(rd_data),
    .bit_cycles_i, .tx_ready_i, .tx_en_o, .tx_valid_o, .tx_data_o
  );

  a_r8_start_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> !tx_en_o);
  a_r5_reply_follows_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_o) |-> $past(frame_ok));
endmodule

// File: tb/slow_node_if_tb.sv
module slow_node_if_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] NODE = 16'h5A3C;
  localparam int BITC = 4;
  localparam int GAPC = 40;
  localparam int BYTE_BUSY = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0, tx_ready = 1'b1;
  logic [7:0] rx_data = 8'h00;
  logic tx_en, tx_valid;
  logic [7:0] tx_data;

  int checks = 0, fails = 0;
  int cap_n = 0, base = 0, busy_cnt = 0, lead_cnt = 0, lead_last = 0, rel_bad = 0;
  logic [7:0] cap [64];
  logic en_d = 1'b0, first = 1'b0;
  logic [7:0] exp_chan [16];

  always #(CLK_PERIOD / 2) clk = ~clk;

  slow_node_if dut_i (
    .clk_i(clk), .rst_ni(rst_n), .node_addr_i(NODE), .gap_cycles_i(16'(GAPC)),
    .bit_cycles_i(16'(BITC)), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .tx_ready_i(tx_ready), .tx_en_o(tx_en), .tx_valid_o(tx_valid), .tx_data_o(tx_data)
  );

  // transmitter model and enable monitor
  always @(posedge clk) begin
    en_d <= tx_en;
    if (tx_en && !en_d) begin
      lead_cnt <= tx_valid ? 0 : 1;
      first    <= 1'b1;
    end else if (tx_en && first && !tx_valid) begin
      lead_cnt <= lead_cnt + 1;
    end
    if (tx_valid && tx_ready) begin
      cap[cap_n % 64] <= tx_data;
      cap_n    <= cap_n + 1;
      tx_ready <= 1'b0;
      busy_cnt <= BYTE_BUSY;
      if (first) begin
        lead_last <= lead_cnt;
        first     <= 1'b0;
      end
    end else if (busy_cnt > 1) begin
      busy_cnt <= busy_cnt - 1;
    end else if (busy_cnt == 1) begin
      busy_cnt <= 0;
      tx_ready <= 1'b1;
    end
    if (!tx_ready && !tx_en) rel_bad <= rel_bad + 1;
  end

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h31) : (r << 1);
    return r;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] cmd, input logic [15:0] addr, input logic [7:0] idx,
                            input logic [23:0] d, input bit corrupt);
    logic [7:0] c;
    base = cap_n;
    c = crc8(8'h00, cmd);
    send_byte(cmd);
    c = crc8(c, addr[15:8]);
    send_byte(addr[15:8]);
    c = crc8(c, addr[7:0]);
    send_byte(addr[7:0]);
    c = crc8(c, idx);
    send_byte(idx);
    for (int k = 0; k < int'(cmd[2:0]); k++) begin
      c = crc8(c, d[8*k +: 8]);
      send_byte(d[8*k +: 8]);
    end
    send_byte(corrupt ? (c ^ 8'h01) : c);
  endtask

  task automatic expect_reply(input int n, input logic [7:0] e0, input logic [7:0] e1,
                              input logic [7:0] e2, input string tag);
    repeat (120) @(negedge clk);
    chk(tag, cap_n - base, n);
    if (cap_n - base == n && n > 0) begin
      chk(tag, int'(cap[base % 64]), int'(e0));
      chk(tag, int'(cap[(base + 1) % 64]), int'(e1));
      if (n > 2) chk(tag, int'(cap[(base + 2) % 64]), int'(e2));
      chk({tag, " R8 lead"}, int'(lead_last >= BITC), 1);
      chk({tag, " R8 en"}, int'(tx_en), 0);
    end
  endtask

  task automatic expect_ack(input string tag);
    expect_reply(2, 8'hA0, crc8(8'h00, 8'hA0), 8'h00, tag);
  endtask

  task automatic expect_read(input logic [7:0] v, input string tag);
    expect_reply(3, 8'hA1, v, crc8(crc8(8'h00, 8'hA1), v), tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 tx_en after reset", int'(tx_en), 0);
    chk("R9 tx_valid after reset", int'(tx_valid), 0);
    send_frame(8'h40, NODE, 8'd17, 24'h0, 1'b0);
    expect_read(8'h00, "R9 chan reset value");

    // sweep both spaces: R4 R5 R6 R2
    for (int i = 0; i < 16; i++) begin
      exp_chan[i] = 8'(i * 29 + 7);
      send_frame(8'h81, NODE, 8'(i * 17), {16'h0, exp_chan[i]}, 1'b0);
      expect_ack("R5 ack on write");
      send_frame(8'h21, NODE, 8'(i * 17), {16'h0, exp_chan[i] ^ 8'hFF}, 1'b0);
      expect_reply(0, 8'h0, 8'h0, 8'h0, "R5 no ack requested");
    end
    for (int i = 0; i < 16; i++) begin
      send_frame(8'h40, NODE, 8'(i * 17), 24'h0, 1'b0);
      expect_read(exp_chan[i], "R6 R4 chan readback");
      send_frame(8'h60, NODE, 8'(i * 17), 24'h0, 1'b0);
      expect_read(exp_chan[i] ^ 8'hFF, "R6 R2 param readback separate");
    end

    // R4 multi-byte wrap past 255
    send_frame(8'h83, NODE, 8'd254, 24'hCCBBAA, 1'b0);
    expect_ack("R4 multi write ack");
    send_frame(8'h40, NODE, 8'd254, 24'h0, 1'b0);
    expect_read(8'hAA, "R4 idx 254");
    send_frame(8'h40, NODE, 8'd255, 24'h0, 1'b0);
    expect_read(8'hBB, "R4 idx 255");
    send_frame(8'h40, NODE, 8'd0, 24'h0, 1'b0);
    expect_read(8'hCC, "R4 wrap idx 0");

    // R7 gap timeout
    send_byte(8'h81);
    send_byte(NODE[15:8]);
    repeat (GAPC + 20) @(negedge clk);
    send_frame(8'h81, NODE, 8'd9, 24'h000077, 1'b0);
    expect_ack("R7 frame after gap");
    send_frame(8'h40, NODE, 8'd9, 24'h0, 1'b0);
    expect_read(8'h77, "R7 value after gap");

    // R1 foreign address with data, then immediate read
    send_frame(8'h82, NODE ^ 16'h0001, 8'd9, 24'h001111, 1'b0);
    chk("R1 no reply foreign", cap_n - base, 0);
    send_frame(8'h40, NODE, 8'd9, 24'h0, 1'b0);
    expect_read(8'h77, "R1 aligned and unchanged");
    send_frame(8'h81, 16'h3C5A, 8'd9, 24'h000011, 1'b0);
    expect_reply(0, 8'h0, 8'h0, 8'h0, "R1 swapped address ignored");

    // R3 bad CRC
    send_frame(8'h81, NODE, 8'd9, 24'h000022, 1'b1);
    expect_reply(0, 8'h0, 8'h0, 8'h0, "R3 bad crc no reply");
    send_frame(8'h40, NODE, 8'd9, 24'h0, 1'b0);
    expect_read(8'h77, "R3 bad crc no write");

    chk("R8 R10 enable covered transmitter busy", rel_bad, 0);
    finish_run();
  end
endmodule